// File: doc/BRIEF.md
# I2C FIFO DMA Request Generator

This block drives the DMA request lines for the transmit and receive byte FIFOs of an I2C controller with a master side and a slave side. Each direction has two request levels. The single request asks the DMA engine to move one byte. The multi request asks it to move a block of bytes. The block reads the FIFO fill levels, the trigger levels, the FIFO-to-slave assignment bits, the slave FIFO mode enables, the slave's "next byte wanted" indication and a global DMA enable. It then raises the request lines that match the active rule.

A direction whose FIFO belongs to the master is controlled by a burst. A burst start command loads the programmed length into a remaining-byte counter. Every byte moved for the burst lowers that counter by one. When the counter is at zero, all master-side requests stay off until the next burst start. A direction whose FIFO belongs to the slave is not gated by the counter. Its requests follow only the slave rules. The remaining count is presented on an output at all times.

All request outputs are registered. A request seen after a clock edge reflects the port values sampled at that edge and the counter value held just before it.

Top module: `i2c_dma_req_gen`

## Requirements
- R1: When `burst_start_i` is high at a clock edge, `remain_o` takes the value of `burst_len_i` and the burst direction takes `burst_dir_i` (0 = transmit, 1 = receive). This also holds in the middle of a burst, and it takes priority over a byte pulse in the same cycle.
- R2: When `byte_xfer_i` is high without a start, `remain_o` drops by one per edge. At zero it stays at zero.
- R3: A direction owned by the master raises no request while the remaining count is zero. This covers the time before any burst, after a burst ends, and after a start with length zero.
- R4: During a master receive burst, `rx_sreq_o` is high when `rx_level_i` is 1 or more. No receive request is raised while the receive FIFO is empty.
- R5: During a master receive burst, `rx_breq_o` is high when `rx_level_i` is 4 or more.
- R6: During a master transmit burst, `tx_sreq_o` is high while `tx_level_i` is below 8 (FIFO not full). `tx_breq_o` is high while `tx_level_i` is below `tx_trig_i`. A burst in one direction raises no master request in the other direction.
- R7: With `dma_en_i` low, all four request outputs are low.
- R8: With `tx_to_slv_i` = 1 and `slv_tx_en_i` = 1, `tx_sreq_o` follows `slv_next_byte_i`, whatever the remaining count is. With `slv_tx_en_i` = 0, no transmit request is raised.
- R9: With `tx_to_slv_i` = 1 and `slv_tx_en_i` = 1, `tx_breq_o` is high while `tx_level_i` < `tx_trig_i`.
- R10: With `rx_to_slv_i` = 1 and `slv_rx_en_i` = 1, `rx_sreq_o` is high whenever `rx_level_i` is nonzero.
- R11: With `rx_to_slv_i` = 1 and `slv_rx_en_i` = 1, `rx_breq_o` is high only when `rx_level_i` > `rx_trig_i`.
- R12: While `rst_ni` is low, all request outputs and `remain_o` are zero.
- R13: Each request output changes one clock edge after the input change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_en_i | input | 1 | Global DMA request enable |
| burst_start_i | input | 1 | Burst start command pulse |
| burst_len_i | input | 8 | Burst length loaded on start |
| burst_dir_i | input | 1 | Burst direction: 0 transmit, 1 receive |
| byte_xfer_i | input | 1 | One burst byte moved through the FIFO |
| tx_level_i | input | 4 | Transmit FIFO fill level (0..8) |
| rx_level_i | input | 4 | Receive FIFO fill level (0..8) |
| tx_trig_i | input | 3 | Transmit trigger level |
| rx_trig_i | input | 3 | Receive trigger level |
| tx_to_slv_i | input | 1 | Transmit FIFO assigned to slave |
| rx_to_slv_i | input | 1 | Receive FIFO assigned to slave |
| slv_tx_en_i | input | 1 | Slave transmit FIFO mode enable |
| slv_rx_en_i | input | 1 | Slave receive FIFO mode enable |
| slv_next_byte_i | input | 1 | Remote master wants the next byte |
| tx_sreq_o | output | 1 | Transmit single request |
| tx_breq_o | output | 1 | Transmit multi request |
| rx_sreq_o | output | 1 | Receive single request |
| rx_breq_o | output | 1 | Receive multi request |
| remain_o | output | 8 | Remaining burst byte count |

## Verification
The remaining count is due one edge after a start or a byte pulse. A request is due one edge after the levels and enables that cause it. It is computed from the counter value held before that edge, so a request reacts to a start or to the last byte pulse only at the second edge. The driver computes both results in its own model at the time it drives the inputs, and pushes them into a queue. The monitor pops one item shortly after each rising edge, so every comparison falls on the cycle where that result first becomes visible.

// File: rtl/i2c_dma_pkg.sv
package i2c_dma_pkg;
  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } burst_dir_e;
endpackage

// File: rtl/i2c_dma_burst_cnt.sv
module i2c_dma_burst_cnt
  import i2c_dma_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             dir_i,
  input  logic             byte_i,
  output logic [LEN_W-1:0] remain_o,
  output logic             tx_act_o,
  output logic             rx_act_o
);
  logic [LEN_W-1:0] cnt_q;
  burst_dir_e       dir_q;
  logic             active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_TX;
    end else if (start_i) begin
      cnt_q <= len_i;
      dir_q <= burst_dir_e'(dir_i);
    end else if (byte_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active   = (cnt_q != '0);
  assign tx_act_o = active && (dir_q == DIR_TX);
  assign rx_act_o = active && (dir_q == DIR_RX);
  assign remain_o = cnt_q;

  assert_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> remain_o == $past(len_i));
  assert_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && byte_i && remain_o != '0) |=> remain_o == LEN_W'($past(remain_o) - 1'b1));
  assert_no_underflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && remain_o == '0) |=> remain_o == '0);
endmodule

// File: rtl/i2c_dma_tx_rule.sv
module i2c_dma_tx_rule #(
  parameter int FIFO_DEPTH = 8,
  parameter int TRIG_W     = 3,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              dma_en_i,
  input  logic              to_slv_i,
  input  logic              slv_en_i,
  input  logic              next_byte_i,
  input  logic              m_act_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [TRIG_W-1:0] trig_i,
  output logic              sreq_o,
  output logic              breq_o
);
  logic below_trig;
  assign below_trig = level_i < LVL_W'(trig_i);

  always_comb begin
    sreq_o = 1'b0;
    breq_o = 1'b0;
    if (dma_en_i) begin
      if (to_slv_i) begin
        sreq_o = slv_en_i & next_byte_i;
        breq_o = slv_en_i & below_trig;
      end else begin
        sreq_o = m_act_i & (level_i < LVL_W'(FIFO_DEPTH));
        breq_o = m_act_i & below_trig;
      end
    end
  end
endmodule

// File: rtl/i2c_dma_rx_rule.sv
module i2c_dma_rx_rule #(
  parameter int FIFO_DEPTH = 8,
  parameter int TRIG_W     = 3,
  parameter int M_MULTI    = 4,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              dma_en_i,
  input  logic              to_slv_i,
  input  logic              slv_en_i,
  input  logic              m_act_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [TRIG_W-1:0] trig_i,
  output logic              sreq_o,
  output logic              breq_o
);
  logic has_data;
  assign has_data = (level_i != '0);

  always_comb begin
    sreq_o = 1'b0;
    breq_o = 1'b0;
    if (dma_en_i) begin
      if (to_slv_i) begin
        sreq_o = slv_en_i & has_data;
        breq_o = slv_en_i & (level_i > LVL_W'(trig_i));
      end else begin
        sreq_o = m_act_i & has_data;
        breq_o = m_act_i & (level_i >= LVL_W'(M_MULTI));
      end
    end
  end
endmodule

// File: rtl/i2c_dma_req_gen.sv
module i2c_dma_req_gen #(
  parameter int FIFO_DEPTH = 8,
  parameter int TRIG_W     = 3,
  parameter int LEN_W      = 8,
  parameter int M_RX_MULTI = 4,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dma_en_i,
  input  logic              burst_start_i,
  input  logic [LEN_W-1:0]  burst_len_i,
  input  logic              burst_dir_i,
  input  logic              byte_xfer_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [TRIG_W-1:0] tx_trig_i,
  input  logic [TRIG_W-1:0] rx_trig_i,
  input  logic              tx_to_slv_i,
  input  logic              rx_to_slv_i,
  input  logic              slv_tx_en_i,
  input  logic              slv_rx_en_i,
  input  logic              slv_next_byte_i,
  output logic              tx_sreq_o,
  output logic              tx_breq_o,
  output logic              rx_sreq_o,
  output logic              rx_breq_o,
  output logic [LEN_W-1:0]  remain_o
);
  logic       m_tx_act, m_rx_act;
  logic [3:0] req_d, req_q; // {tx_s, tx_b, rx_s, rx_b}

  i2c_dma_burst_cnt #(.LEN_W(LEN_W)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (burst_start_i),
    .len_i    (burst_len_i),
    .dir_i    (burst_dir_i),
    .byte_i   (byte_xfer_i),
    .remain_o (remain_o),
    .tx_act_o (m_tx_act),
    .rx_act_o (m_rx_act)
  );

  i2c_dma_tx_rule #(.FIFO_DEPTH(FIFO_DEPTH), .TRIG_W(TRIG_W)) i_tx (
    .dma_en_i    (dma_en_i),
    .to_slv_i    (tx_to_slv_i),
    .slv_en_i    (slv_tx_en_i),
    .next_byte_i (slv_next_byte_i),
    .m_act_i     (m_tx_act),
    .level_i     (tx_level_i),
    .trig_i      (tx_trig_i),
    .sreq_o      (req_d[3]),
    .breq_o      (req_d[2])
  );

  i2c_dma_rx_rule #(.FIFO_DEPTH(FIFO_DEPTH), .TRIG_W(TRIG_W), .M_MULTI(M_RX_MULTI)) i_rx (
    .dma_en_i (dma_en_i),
    .to_slv_i (rx_to_slv_i),
    .slv_en_i (slv_rx_en_i),
    .m_act_i  (m_rx_act),
    .level_i  (rx_level_i),
    .trig_i   (rx_trig_i),
    .sreq_o   (req_d[1]),
    .breq_o   (req_d[0])
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_d;
  end

  assign {tx_sreq_o, tx_breq_o, rx_sreq_o, rx_breq_o} = req_q;

  assert_dma_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_i |=> !(tx_sreq_o || tx_breq_o || rx_sreq_o || rx_breq_o));
  assert_rx_multi_has_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_breq_o |-> rx_sreq_o);
  assert_master_tx_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remain_o == '0 && !tx_to_slv_i) |=> !(tx_sreq_o || tx_breq_o));
  assert_master_rx_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remain_o == '0 && !rx_to_slv_i) |=> !(rx_sreq_o || rx_breq_o));
endmodule

// File: tb/test_i2c_dma_req_gen.sv
module test_i2c_dma_req_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dma_en = 0, start = 0, dir = 0, xfer = 0;
  logic [7:0] len = 0;
  logic [3:0] tx_lvl = 0, rx_lvl = 0;
  logic [2:0] tx_trig = 0, rx_trig = 0;
  logic       tx_slv = 0, rx_slv = 0, stx_en = 0, srx_en = 0, nxt = 0;
  logic       tx_s, tx_b, rx_s, rx_b;
  logic [7:0] rem;

  int total = 0, bad = 0;
  bit done = 0;

  logic [11:0] q_exp[$];
  string       q_tag[$];
  logic [7:0]  m_rem = 0;
  logic        m_dir = 0;

  always #2.5 clk = ~clk;

  i2c_dma_req_gen i_i2c_dma_req_gen (
    .clk_i(clk), .rst_ni(rst_n), .dma_en_i(dma_en), .burst_start_i(start),
    .burst_len_i(len), .burst_dir_i(dir), .byte_xfer_i(xfer),
    .tx_level_i(tx_lvl), .rx_level_i(rx_lvl), .tx_trig_i(tx_trig), .rx_trig_i(rx_trig),
    .tx_to_slv_i(tx_slv), .rx_to_slv_i(rx_slv), .slv_tx_en_i(stx_en), .slv_rx_en_i(srx_en),
    .slv_next_byte_i(nxt), .tx_sreq_o(tx_s), .tx_breq_o(tx_b), .rx_sreq_o(rx_s),
    .rx_breq_o(rx_b), .remain_o(rem)
  );

  function automatic logic [3:0] model_req();
    logic ts, tb, rs, rb;
    logic tact, ract;
    ts = 0; tb = 0; rs = 0; rb = 0;
    tact = (m_rem != 0) && (m_dir == 1'b0);
    ract = (m_rem != 0) && (m_dir == 1'b1);
    if (dma_en) begin
      if (tx_slv) begin
        ts = stx_en & nxt;
        tb = stx_en & (tx_lvl < {1'b0, tx_trig});
      end else begin
        ts = tact & (tx_lvl < 4'd8);
        tb = tact & (tx_lvl < {1'b0, tx_trig});
      end
      if (rx_slv) begin
        rs = srx_en & (rx_lvl != 0);
        rb = srx_en & (rx_lvl > {1'b0, rx_trig});
      end else begin
        rs = ract & (rx_lvl >= 4'd1);
        rb = ract & (rx_lvl >= 4'd4);
      end
    end
    return {ts, tb, rs, rb};
  endfunction

  // driver: called right after a falling edge with inputs set
  task automatic step(input string tag);
    logic [3:0] r;
    r = model_req();
    if (start) begin
      m_rem = len;
      m_dir = dir;
    end else if (xfer && m_rem != 0) begin
      m_rem = m_rem - 1;
    end
    q_exp.push_back({r, m_rem});
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (q_exp.size() != 0) begin
      logic [11:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      total++;
      if ({tx_s, tx_b, rx_s, rx_b, rem} !== e) begin
        bad++;
        $display("FAIL %s: got req=%b rem=%0d expected req=%b rem=%0d",
                 t, {tx_s, tx_b, rx_s, rx_b}, rem, e[11:8], e[7:0]);
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    dma_en = 1;
    repeat (3) @(negedge clk);
    total++;
    if ({tx_s, tx_b, rx_s, rx_b, rem} !== 12'h000) begin
      bad++;
      $display("FAIL R12: got %h expected 000", {tx_s, tx_b, rx_s, rx_b, rem});
    end
    rst_n = 1;
    @(negedge clk);

    // master, no burst yet
    tx_lvl = 0; rx_lvl = 5; tx_trig = 5;
    step("R3");
    // zero-length burst
    start = 1; len = 0; dir = 1; step("R3"); start = 0;
    step("R3");
    // receive burst of 3
    rx_lvl = 0; start = 1; len = 3; step("R1"); start = 0;
    step("R4");
    rx_lvl = 2; step("R13");
    step("R4");
    rx_lvl = 4; step("R5");
    step("R5");
    rx_lvl = 3; step("R5");
    rx_lvl = 5;
    xfer = 1; step("R2"); step("R2"); step("R2"); step("R2"); xfer = 0;
    step("R3");
    step("R3");
    // reload mid-burst with simultaneous byte pulse
    start = 1; len = 10; step("R1"); start = 0;
    xfer = 1; step("R2"); step("R2");
    start = 1; len = 6; step("R1"); start = 0; xfer = 0;
    step("R1");
    // transmit burst
    start = 1; len = 4; dir = 0; tx_lvl = 2; rx_lvl = 6; step("R1"); start = 0;
    step("R6");
    step("R6");
    tx_lvl = 6; step("R6");
    step("R6");
    tx_lvl = 8; step("R6");
    step("R6");
    // dma off
    tx_lvl = 1; dma_en = 0; step("R7");
    step("R7");
    tx_slv = 1; rx_slv = 1; stx_en = 1; srx_en = 1; nxt = 1; step("R7");
    step("R7");
    dma_en = 1;
    // slave transmit, counter state ignored
    start = 1; len = 0; step("R8"); start = 0;
    tx_lvl = 7; tx_trig = 3; nxt = 1; rx_lvl = 0; step("R8");
    step("R8");
    nxt = 0; tx_lvl = 1; step("R9");
    step("R9");
    tx_lvl = 3; step("R9");
    step("R9");
    stx_en = 0; nxt = 1; tx_lvl = 0; step("R8");
    step("R8");
    // slave receive
    rx_trig = 3; rx_lvl = 0; step("R10");
    step("R10");
    rx_lvl = 3; step("R11");
    step("R11");
    rx_lvl = 4; step("R11");
    step("R11");
    rx_lvl = 1; rx_trig = 0; step("R10");
    step("R10");
    srx_en = 0; step("R10");
    step("R10");

    repeat (3) @(posedge clk);
    #3;
    // reset mid-run clears count and requests
    srx_en = 1; rx_slv = 0; start = 1; len = 9; dir = 1; rx_lvl = 5;
    @(negedge clk); start = 0;
    @(negedge clk);
    rst_n = 0;
    #1;
    total++;
    if ({tx_s, tx_b, rx_s, rx_b, rem} !== 12'h000) begin
      bad++;
      $display("FAIL R12: got %h expected 000", {tx_s, tx_b, rx_s, rx_b, rem});
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule